// File: doc/BRIEF.md
# Parallel Port Extended Control Register File

This block is the small register file that sits in front of an extended-capability parallel port. A processor reaches it through a plain byte bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. Three addresses are decoded. The main control byte at offset 402h selects the port mode. It also holds the fault-interrupt mask, the DMA enable and the service-interrupt flag, and it reports whether the FIFO is full or empty. Two configuration bytes at 400h and 401h are visible only in configuration mode (mode 111).

The block watches the FIFO fill level, the transfer direction, the DMA terminal count, the external active-low fault pin and the interrupt request line. It drives the selected mode, a gated DMA enable, a one-cycle fault interrupt pulse and a one-cycle service interrupt pulse. The service flag is set by hardware when the condition chosen by the DMA and direction settings becomes true. Software must clear the flag to re-arm it.

A fault interrupt is also raised when software unmasks the fault interrupt while the pin is already low. This covers a falling edge that arrives between a read of the control byte and the write that unmasks the interrupt.

Top module: `pport_ctl_regs`

## Requirements
- R1: Offset 402h is writable in every mode. Bit fields: bits 7:5 = mode, bit 4 = fault mask, bit 3 = DMA enable, bit 2 = service flag, bit 1 = full, bit 0 = empty. Bits 7:2 read back what was written, and the mode output follows bits 7:5. After reset the mode is 000, the mask is 1, DMA enable is 0 and the service flag is 1, so a read of 402h with an empty FIFO returns 15h.
- R2: Bit 1 of 402h reads 1 exactly when the FIFO level equals the depth (16). Bit 0 reads 1 exactly when the level is 0. Writes to bits 1:0 have no effect.
- R3: While the mask is 0, each high-to-low transition of the fault pin produces exactly one fault_irq pulse, one clock wide, after a two-flop synchroniser. While the mask is 1, transitions produce no pulse.
- R4: Writing 402h with bit 4 = 0 while the mask is 1 and the synchronised fault pin is low produces one fault_irq pulse. The same write with the pin high produces none. A write of 0 when the mask is already 0 produces none.
- R5: dma_enable is 1 exactly when the DMA enable bit is 1 and the service flag is 0.
- R6: With DMA enable = 1, the service condition is term_count = 1. FIFO level and direction are ignored.
- R7: With DMA enable = 0 and xfer_dir = 0, the service condition is a free-byte count (16 minus level) of 8 or more. term_count is ignored.
- R8: With DMA enable = 0 and xfer_dir = 1, the service condition is a level of 8 or more.
- R9: While the service flag is 0 and the condition is true, hardware sets the flag and svc_irq pulses for one cycle. The flag then stays 1 until software writes 0. A write of 1 never produces a pulse.
- R10: In mode 111, offset 400h reads 10h. Offset 401h reads with bit 6 = irq_line and all other bits 0. In any other mode both offsets read 00h. Writes to 400h and 401h change no state.
- R11: rdata is loaded on the clock edge that samples rd_en and holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 11 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| fifo_level | input | 5 | Valid bytes in the FIFO (0..16) |
| xfer_dir | input | 1 | Transfer direction, 1 = toward host |
| term_count | input | 1 | DMA terminal count reached |
| nfault_pin | input | 1 | Asynchronous active-low fault pin |
| irq_line | input | 1 | Live interrupt request line |
| mode | output | 3 | Selected port mode |
| dma_enable | output | 1 | DMA request permission |
| fault_irq | output | 1 | One-cycle fault interrupt pulse |
| svc_irq | output | 1 | One-cycle service interrupt pulse |

## Verification
The service logic is swept over every FIFO level from 0 to 16 in both directions, with term_count toggling on alternate levels. This separates the free-byte threshold from the valid-byte threshold, locates each boundary at exactly eight, and shows that terminal count is ignored while DMA is off. The FIFO is then held full and the terminal count is pulsed with DMA enabled, which shows that the level stops mattering in that case. All eight modes are walked while reading all three offsets, which separates configuration-mode visibility from normal mode. The fault sequences combine masked edges, unmasked edges, and unmask writes with the pin low and with the pin high, so that a missing or duplicate retroactive pulse can be told apart from an ordinary edge pulse.

// File: rtl/pport_ctl_pkg.sv
// Package: shared offsets and constants for the parallel port control
// register file. Assumes an 11-bit offset bus and byte-wide registers.
package pport_ctl_pkg;
    localparam int          ADDR_W      = 11;
    localparam logic [10:0] OFS_CFG_A   = 11'h400;
    localparam logic [10:0] OFS_CFG_B   = 11'h401;
    localparam logic [10:0] OFS_CTL     = 11'h402;
    localparam logic [2:0]  MODE_CFG    = 3'b111;
    localparam logic [7:0]  CFG_A_VALUE = 8'h10;

    // Software-visible control fields of the main control byte.
    typedef struct packed {
        logic [2:0] mode;
        logic       fault_mask;
        logic       dma_on;
        logic       svc_flag;
    } ctl_fields_t;
endpackage

// File: rtl/pport_fault_irq.sv
// Fault interrupt generator. Synchronises the asynchronous active-low
// fault pin and pulses for one cycle on an unmasked falling edge. It also
// pulses when software clears the mask while the synchronised pin is low.
// Assumes the pin idles high.
module pport_fault_irq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nfault_pin,
    input  logic mask_q,
    input  logic ctl_wr,
    input  logic wr_mask_val,
    output logic irq
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pin_s;
    logic                   fall;
    logic                   unmask_low;
    logic                   irq_q;

    // Synchroniser chain, reset to the idle-high level.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= nfault_pin;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], nfault_pin};
            end
        end
    endgenerate

    assign pin_s      = sync_q[SYNC_STAGES-1];
    assign fall       = prev_q & ~pin_s;
    assign unmask_low = ctl_wr & mask_q & ~wr_mask_val & ~pin_s;

    // Edge history and registered one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            irq_q  <= 1'b0;
        end else begin
            prev_q <= pin_s;
            irq_q  <= (fall & ~mask_q) | unmask_low;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/pport_svc_ctl.sv
// Service flag controller. Picks the service condition from the DMA and
// direction settings, sets the sticky flag in hardware and pulses the
// service interrupt. A software write to the flag takes priority over
// the hardware set in the same cycle. It also derives FIFO full and empty.
module pport_svc_ctl #(
    parameter int DEPTH  = 16,
    parameter int WR_THR = 8,
    parameter int RD_THR = 8,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic             dir,
    input  logic             tc,
    input  logic             dma_q,
    input  logic             ctl_wr,
    input  logic             wr_flag_val,
    output logic             svc_q,
    output logic             irq,
    output logic             full,
    output logic             empty
);
    logic [LVL_W-1:0] free_cnt;
    logic             cond;
    logic             flag_q;
    logic             irq_q;

    assign free_cnt = LVL_W'(DEPTH) - level;

    // Service condition selection.
    always_comb begin
        if (dma_q)    cond = tc;
        else if (dir) cond = (level >= LVL_W'(RD_THR));
        else          cond = (free_cnt >= LVL_W'(WR_THR));
    end

    // Sticky flag and one-shot interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b1;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= ctl_wr ? wr_flag_val : (flag_q | cond);
            irq_q  <= ~ctl_wr & ~flag_q & cond;
        end
    end

    assign svc_q = flag_q;
    assign irq   = irq_q;
    assign full  = (level >= LVL_W'(DEPTH));
    assign empty = (level == '0);
endmodule

// File: rtl/pport_rd_mux.sv
// Read path. Selects the addressed byte and registers it on the read
// strobe. The configuration bytes read as zero outside mode 111.
module pport_rd_mux
    import pport_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cfg_mode,
    input  logic [7:0]        ctl_byte,
    input  logic              irq_line,
    output logic [7:0]        rdata
);
    logic [7:0] sel;
    logic [7:0] rdata_q;

    // Address decode of the readable bytes.
    always_comb begin
        sel = 8'h00;
        if (addr == OFS_CTL)                    sel = ctl_byte;
        else if (cfg_mode && addr == OFS_CFG_A) sel = CFG_A_VALUE;
        else if (cfg_mode && addr == OFS_CFG_B) sel = {1'b0, irq_line, 6'b0};
    end

    // Capture on the read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= 8'h00;
        else if (rd_en) rdata_q <= sel;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/pport_ctl_regs.sv
// Top of the parallel port control register file. Holds the mode, fault
// mask and DMA enable, and instantiates the fault interrupt, service flag
// and read path blocks. Assumes a single-clock bus whose strobes last
// one cycle each.
module pport_ctl_regs
    import pport_ctl_pkg::*;
#(
    parameter  int DEPTH       = 16,
    parameter  int WR_THR      = 8,
    parameter  int RD_THR      = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int LVL_W       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              xfer_dir,
    input  logic              term_count,
    input  logic              nfault_pin,
    input  logic              irq_line,
    output logic [2:0]        mode,
    output logic              dma_enable,
    output logic              fault_irq,
    output logic              svc_irq
);
    ctl_fields_t wfld;
    logic        ctl_wr;
    logic [2:0]  mode_q;
    logic        mask_q;
    logic        dma_q;
    logic        svc_q;
    logic        full;
    logic        empty;
    logic [7:0]  ctl_byte;
    logic        unused_wdata_lo;

    assign wfld            = ctl_fields_t'(wdata[7:2]);
    assign unused_wdata_lo = ^wdata[1:0];
    assign ctl_wr          = wr_en && (addr == OFS_CTL);

    // Software-owned control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 3'b000;
            mask_q <= 1'b1;
            dma_q  <= 1'b0;
        end else if (ctl_wr) begin
            mode_q <= wfld.mode;
            mask_q <= wfld.fault_mask;
            dma_q  <= wfld.dma_on;
        end
    end

    pport_fault_irq #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .nfault_pin (nfault_pin),
        .mask_q     (mask_q),
        .ctl_wr     (ctl_wr),
        .wr_mask_val(wfld.fault_mask),
        .irq        (fault_irq)
    );

    pport_svc_ctl #(.DEPTH(DEPTH), .WR_THR(WR_THR), .RD_THR(RD_THR), .LVL_W(LVL_W)) u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (fifo_level),
        .dir        (xfer_dir),
        .tc         (term_count),
        .dma_q      (dma_q),
        .ctl_wr     (ctl_wr),
        .wr_flag_val(wfld.svc_flag),
        .svc_q      (svc_q),
        .irq        (svc_irq),
        .full       (full),
        .empty      (empty)
    );

    assign ctl_byte = {mode_q, mask_q, dma_q, svc_q, full, empty};

    pport_rd_mux u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .addr    (addr),
        .cfg_mode(mode_q == MODE_CFG),
        .ctl_byte(ctl_byte),
        .irq_line(irq_line),
        .rdata   (rdata)
    );

    assign mode       = mode_q;
    assign dma_enable = dma_q & ~svc_q;
endmodule

// File: rtl/pport_ctl_regs_chk.sv
// Checker for the control register file, bound to the top module.
// Assumes a synchronous active-low reset.
module pport_ctl_regs_chk
    import pport_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        rdata,
    input logic [2:0]        mode,
    input logic              dma_enable,
    input logic              fault_irq,
    input logic              svc_irq,
    input logic              svc_q
);
    // R3
    fault_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_irq |=> !fault_irq);

    // R9
    svc_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |=> !svc_irq);

    // R9
    svc_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTL) |=> !svc_irq);

    // R9
    svc_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |-> svc_q);

    // R5
    svc_blocks_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |-> !dma_enable);

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_CTL) |=> $stable(mode));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R10
    cfg_a_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_CFG_A && mode == MODE_CFG) |=> rdata == CFG_A_VALUE);
endmodule

bind pport_ctl_regs pport_ctl_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .mode      (mode),
    .dma_enable(dma_enable),
    .fault_irq (fault_irq),
    .svc_irq   (svc_irq),
    .svc_q     (svc_q)
);

// File: tb/pport_ctl_regs_test.sv
// Self-checking bench for pport_ctl_regs: sweeps levels, directions and
// modes, and runs fault-pin sequences, with expectations computed here.
module pport_ctl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [4:0]  fifo_level = '0;
    logic        xfer_dir = 1'b1;
    logic        term_count = 1'b0;
    logic        nfault_pin = 1'b1;
    logic        irq_line = 1'b0;
    logic [2:0]  mode;
    logic        dma_enable, fault_irq, svc_irq;

    int checks = 0, failures = 0;
    int fault_cnt = 0, svc_cnt = 0;
    logic fault_prev = 1'b0, fault_wide = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pport_ctl_regs uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .fifo_level(fifo_level), .xfer_dir(xfer_dir),
        .term_count(term_count), .nfault_pin(nfault_pin), .irq_line(irq_line),
        .mode(mode), .dma_enable(dma_enable), .fault_irq(fault_irq), .svc_irq(svc_irq)
    );

    // Pulse counters sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fault_irq) fault_cnt++;
            if (svc_irq)   svc_cnt++;
            if (fault_irq && fault_prev) fault_wide = 1'b1;
            fault_prev = fault_irq;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2;
        int f0, s0;
        idle(3); rst_n = 1'b1; idle(2);

        // R1 R2 reset state
        rd(11'h402, v);
        check("R1 reset ctl byte", v, 8'h15);
        check("R1 reset mode", mode, 0);
        check("R5 reset dma_enable", dma_enable, 0);

        // R6 R7 R8 R9 R2: level sweep in both directions, DMA off
        for (int dir = 0; dir < 2; dir++) begin
            for (int lvl = 0; lvl <= 16; lvl++) begin
                bit cond;
                fifo_level = 5'(lvl); xfer_dir = dir[0]; term_count = lvl[0];
                cond = dir ? (lvl >= 8) : ((16 - lvl) >= 8);
                idle(1); s0 = svc_cnt;
                wr(11'h402, 8'h10);
                idle(3);
                rd(11'h402, v);
                check(dir ? "R8 ctl byte" : "R7 ctl byte", v,
                      8'h10 | (int'(cond) << 2) | (int'(lvl == 16) << 1) | int'(lvl == 0));
                check(dir ? "R8 svc pulses" : "R7 svc pulses", svc_cnt - s0, int'(cond));
                s0 = svc_cnt;
                wr(11'h402, 8'h14);
                idle(2);
                check("R9 write one quiet", svc_cnt - s0, 0);
            end
        end

        // R6 R5 R9: DMA mode selects terminal count, level ignored
        fifo_level = 5'd16; xfer_dir = 1'b0; term_count = 1'b0;
        s0 = svc_cnt;
        wr(11'h402, 8'h18); idle(3);
        check("R6 level ignored with dma", svc_cnt - s0, 0);
        check("R5 dma_enable on", dma_enable, 1);
        term_count = 1'b1; idle(3); term_count = 1'b0;
        check("R6 tc sets svc", svc_cnt - s0, 1);
        check("R5 dma_enable off after svc", dma_enable, 0);
        rd(11'h402, v);
        check("R9 flag sticky", v, 8'h1E);
        term_count = 1'b1; s0 = svc_cnt;
        wr(11'h402, 8'h1C); idle(3);
        check("R9 write one with tc high", svc_cnt - s0, 0);
        wr(11'h402, 8'h18); idle(3);
        check("R9 rearm pulses", svc_cnt - s0, 1);
        term_count = 1'b0;
        wr(11'h402, 8'h14);

        // R1 R10: mode walk and configuration bytes
        fifo_level = 5'd5; xfer_dir = 1'b1; irq_line = 1'b1;
        for (int m = 0; m < 8; m++) begin
            wr(11'h402, 8'((m << 5) | 8'h14));
            check("R1 mode output", mode, m);
            wr(11'h400, 8'hFF);
            wr(11'h401, 8'hFF);
            rd(11'h402, v);
            check("R10 cfg writes ignored", v, (m << 5) | 8'h14);
            rd(11'h400, v);
            check("R10 cfg A", v, (m == 7) ? 8'h10 : 8'h00);
            rd(11'h401, v);
            check("R10 cfg B irq high", v, (m == 7) ? 8'h40 : 8'h00);
        end
        irq_line = 1'b0;
        rd(11'h401, v);
        check("R10 cfg B irq low", v, 8'h00);

        // R11: read data holds without a strobe
        rd(11'h402, v);
        fifo_level = 5'd0; idle(3);
        check("R11 rdata hold", rdata, v);
        rd(11'h402, v2);
        check("R11 new read", v2, 8'hF5);
        wr(11'h402, 8'h14);

        // R3 R4: fault pin sequences (DMA off, direction 1, level 0)
        nfault_pin = 1'b1; idle(5); f0 = fault_cnt;
        nfault_pin = 1'b0; idle(6);
        check("R3 masked edge", fault_cnt - f0, 0);
        wr(11'h402, 8'h04); idle(3);
        check("R4 unmask with pin low", fault_cnt - f0, 1);
        f0 = fault_cnt;
        wr(11'h402, 8'h04); idle(3);
        check("R4 already unmasked", fault_cnt - f0, 0);
        nfault_pin = 1'b1; idle(5); f0 = fault_cnt;
        nfault_pin = 1'b0; idle(6);
        check("R3 unmasked edge", fault_cnt - f0, 1);
        nfault_pin = 1'b1; idle(5);
        nfault_pin = 1'b0; idle(6);
        check("R3 second edge", fault_cnt - f0, 2);
        nfault_pin = 1'b1; idle(5);
        wr(11'h402, 8'h14); f0 = fault_cnt;
        wr(11'h402, 8'h04); idle(3);
        check("R4 unmask with pin high", fault_cnt - f0, 0);
        check("R3 pulse width one", fault_wide, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule